// File: doc/BRIEF.md
# SPI event request router

This block sits beside an SPI controller's FIFOs and shifter. It turns six event sources into a single interrupt line and two DMA request lines. Four sources are latched events: end of queue, transfer done, TX underrun and RX overflow. Each is kept in a sticky flag until software clears it. The other two are live FIFO levels: TX has room and RX holds data. A per-source select bit routes each of these two either to the interrupt line or to its own DMA request.

Software reaches the block through a small register port. The status register shows the six flags and takes write-one-to-clear for the sticky ones. The control register holds six per-source enables and the two routing selects. The FIFO side drives single-cycle event pulses and the two level signals, and acknowledges DMA transfers with one-cycle pulses.

Top module: `spi_req_router`

## Requirements
- R1: After reset all sticky flags, all enables and both routing selects are 0, so `irq`, `tx_dma_req` and `rx_dma_req` are low and the control register reads 0x00.
- R2: Address 0 is status: bit0 end-of-queue, bit1 TX-room, bit2 transfer-done, bit3 TX-underrun, bit4 RX-data, bit5 RX-overflow, bits 7:6 read 0. Address 1 is control: bits 5:0 enable the source in the same bit position, bit6 routes TX-room to DMA when 1, and bit7 routes RX-data to DMA when 1. A control write is visible from the next cycle, and `reg_rdata` is combinational on `reg_addr`.
- R3: An event pulse on a latched source sets its flag in the cycle after the pulse. The flag stays set until it is cleared.
- R4: A status write with a 1 in a sticky bit clears that flag. A 0 leaves it unchanged. Bits 1 and 4 of a status write have no effect.
- R5: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Status bit1 reads 1 exactly while `tx_fifo_full` is low, and status bit4 reads 1 exactly while `rx_fifo_empty` is low.
- R7: `irq` is the OR, over every source not routed to DMA, of its flag AND its enable.
- R8: A source routed to DMA never drives `irq`. Its DMA request is its flag AND its enable.
- R9: A DMA acknowledge pulse forces the matching request low for the one following cycle. After that the request follows R8 again.
- R10: The end-of-queue flag is set by the pulse marking a command that carries the end-of-queue marker. It raises `irq` only while enable bit0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| eoq_evt | input | 1 | Pulse: executed command carried end-of-queue marker |
| xfer_done_evt | input | 1 | Pulse: a transfer finished |
| tx_underrun_evt | input | 1 | Pulse: TX FIFO underran |
| rx_overflow_evt | input | 1 | Pulse: RX FIFO overflowed |
| tx_fifo_full | input | 1 | TX FIFO is full |
| rx_fifo_empty | input | 1 | RX FIFO is empty |
| tx_dma_ack | input | 1 | Pulse: TX DMA transfer accepted |
| rx_dma_ack | input | 1 | Pulse: RX DMA transfer accepted |
| irq | output | 1 | Combined interrupt request |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
With all four sticky flags set, a vector table steps the control register through single enables, enable-plus-route pairs, a route bit with its enable clear, and both FIFO levels at either value. This separates a source that is gated off by its enable from one diverted to DMA, and both from one blocked because its FIFO level is inactive. Directed patterns then cover the clearing writes: a 1, a 0, and writes to the level-driven bits, which show whether clearing is per bit and whether the live bits can be written. Further patterns collide an event with its clear, and pulse an acknowledge to check that the request gap lasts exactly one cycle.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 1;
    localparam int N_STICKY  = 4;
    localparam int N_SRC     = 6;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 1'b1;

    // status / enable bit positions
    localparam int B_EOQ   = 0;
    localparam int B_TXRM  = 1;
    localparam int B_DONE  = 2;
    localparam int B_UNDR  = 3;
    localparam int B_RXDT  = 4;
    localparam int B_OVF   = 5;
    localparam int B_TXSEL = 6;
    localparam int B_RXSEL = 7;
endpackage

// File: rtl/spi_req_sticky.sv
module spi_req_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R3 / R5: a set pulse always lands, even against a clear
        a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        // R4: a clear without a set empties the flag
        a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        // R3: a set flag persists without a clear
        a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    end
endmodule

// File: rtl/spi_req_steer.sv
module spi_req_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic en_i,
    input  logic dma_sel_i,
    input  logic ack_i,
    output logic irq_o,
    output logic req_o
);
    typedef struct packed {
        logic gap;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.gap = ack_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = flag_i & en_i & ~dma_sel_i;
    assign req_o = flag_i & en_i & dma_sel_i & ~st_q.gap;

    // R9: the cycle after an acknowledge carries no request
    a_r9_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !req_o);
endmodule

// File: rtl/spi_req_regs.sv
module spi_req_regs
    import spi_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [N_STICKY-1:0] clr_o
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
    } state_t;

    state_t st_d, st_q;
    logic   wr_status;

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == ADDR_CTRL) st_d.ctrl = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_status = wr_i && (addr_i == ADDR_STATUS);
    // sticky order: eoq, done, underrun, overflow
    assign clr_o  = wr_status ? {wdata_i[B_OVF], wdata_i[B_UNDR],
                                 wdata_i[B_DONE], wdata_i[B_EOQ]} : '0;
    assign ctrl_o = st_q.ctrl;

    // R2: a control write is visible on the next cycle
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_CTRL) |=> ctrl_o == $past(wdata_i));
    a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_CTRL) |=> $stable(ctrl_o));
endmodule

// File: rtl/spi_req_router.sv
module spi_req_router
    import spi_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eoq_evt,
    input  logic              xfer_done_evt,
    input  logic              tx_underrun_evt,
    input  logic              rx_overflow_evt,
    input  logic              tx_fifo_full,
    input  logic              rx_fifo_empty,
    input  logic              tx_dma_ack,
    input  logic              rx_dma_ack,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    logic [REG_W-1:0]    ctrl;
    logic [N_STICKY-1:0] clr, sticky;
    logic [N_SRC-1:0]    status6;
    logic                tx_irq, rx_irq, sticky_irq;

    spi_req_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .addr_i (reg_addr),
        .wdata_i(reg_wdata),
        .ctrl_o (ctrl),
        .clr_o  (clr)
    );

    spi_req_sticky #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({rx_overflow_evt, tx_underrun_evt, xfer_done_evt, eoq_evt}),
        .clr_i (clr),
        .flag_o(sticky)
    );

    spi_req_steer u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (status6[B_TXRM]),
        .en_i     (ctrl[B_TXRM]),
        .dma_sel_i(ctrl[B_TXSEL]),
        .ack_i    (tx_dma_ack),
        .irq_o    (tx_irq),
        .req_o    (tx_dma_req)
    );

    spi_req_steer u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (status6[B_RXDT]),
        .en_i     (ctrl[B_RXDT]),
        .dma_sel_i(ctrl[B_RXSEL]),
        .ack_i    (rx_dma_ack),
        .irq_o    (rx_irq),
        .req_o    (rx_dma_req)
    );

    always_comb begin
        status6         = '0;
        status6[B_EOQ]  = sticky[0];
        status6[B_DONE] = sticky[1];
        status6[B_UNDR] = sticky[2];
        status6[B_OVF]  = sticky[3];
        status6[B_TXRM] = ~tx_fifo_full;
        status6[B_RXDT] = ~rx_fifo_empty;
    end

    assign sticky_irq = (sticky[0] & ctrl[B_EOQ])  | (sticky[1] & ctrl[B_DONE]) |
                        (sticky[2] & ctrl[B_UNDR]) | (sticky[3] & ctrl[B_OVF]);
    assign irq        = sticky_irq | tx_irq | rx_irq;
    assign reg_rdata  = (reg_addr == ADDR_STATUS) ?
                        {{(REG_W-N_SRC){1'b0}}, status6} : ctrl;

    // R8: DMA requests appear only when routed and enabled
    a_r8_txreq_routed: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (ctrl[B_TXSEL] && ctrl[B_TXRM] && !tx_fifo_full));
    a_r8_rxreq_routed: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (ctrl[B_RXSEL] && ctrl[B_RXDT] && !rx_fifo_empty));
    // R7: no enable, no interrupt
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[N_SRC-1:0] == '0) |-> !irq);
    // R10: end-of-queue pulse latches its flag
    a_r10_eoq_latch: assert property (@(posedge clk) disable iff (!rst_n)
        eoq_evt |=> sticky[0]);
endmodule

// File: tb/spi_req_router_tb_top.sv
module spi_req_router_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic eoq_evt = 0, xfer_done_evt = 0, tx_underrun_evt = 0, rx_overflow_evt = 0;
    logic tx_fifo_full = 1, rx_fifo_empty = 1, tx_dma_ack = 0, rx_dma_ack = 0;
    logic irq, tx_dma_req, rx_dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_req_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eoq_evt(eoq_evt),
        .xfer_done_evt(xfer_done_evt), .tx_underrun_evt(tx_underrun_evt),
        .rx_overflow_evt(rx_overflow_evt), .tx_fifo_full(tx_fifo_full),
        .rx_fifo_empty(rx_fifo_empty), .tx_dma_ack(tx_dma_ack),
        .rx_dma_ack(rx_dma_ack), .irq(irq), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req)
    );

    // {ctrl[7:0], tx_full, rx_empty, exp_irq, exp_txreq, exp_rxreq}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {8'h00, 1'b1, 1'b1, 3'b000},
        {8'h01, 1'b1, 1'b1, 3'b100},
        {8'h04, 1'b1, 1'b1, 3'b100},
        {8'h28, 1'b1, 1'b1, 3'b100},
        {8'h02, 1'b1, 1'b1, 3'b000},
        {8'h02, 1'b0, 1'b1, 3'b100},
        {8'h42, 1'b0, 1'b1, 3'b010},
        {8'h40, 1'b0, 1'b1, 3'b000},
        {8'h10, 1'b1, 1'b0, 3'b100},
        {8'h90, 1'b1, 1'b0, 3'b001},
        {8'hD2, 1'b0, 1'b0, 3'b011},
        {8'h80, 1'b0, 1'b0, 3'b000}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // mask bits: 0 eoq, 1 done, 2 underrun, 3 overflow
    task automatic pulse(input logic [3:0] m);
        {rx_overflow_evt, tx_underrun_evt, xfer_done_evt, eoq_evt} = m;
        @(negedge clk);
        {rx_overflow_evt, tx_underrun_evt, xfer_done_evt, eoq_evt} = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 dma", {6'd0, tx_dma_req, rx_dma_req}, 8'h00);
        rd(1'b1, r); check("R1 ctrl", r, 8'h00);
        rd(1'b0, r); check("R1 status", r, 8'h00);

        // R6 live level bits
        tx_fifo_full = 1'b0; rd(1'b0, r); check("R6 txroom", r, 8'h02);
        tx_fifo_full = 1'b1; rx_fifo_empty = 1'b0; rd(1'b0, r); check("R6 rxdata", r, 8'h10);
        rx_fifo_empty = 1'b1;

        // R3 sticky set
        pulse(4'b0010); rd(1'b0, r); check("R3 done", r, 8'h04);
        pulse(4'b1101); rd(1'b0, r); check("R3 all", r, 8'h2D);
        @(negedge clk); rd(1'b0, r); check("R3 hold", r, 8'h2D);
        // R10 eoq without enable
        check("R10 no enable", {7'd0, irq}, 8'h00);

        // R7 R8 R10 table walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b1, VEC[i][12:5]);
            tx_fifo_full = VEC[i][4]; rx_fifo_empty = VEC[i][3];
            #1;
            check($sformatf("R7/R8 vec%0d", i), {5'd0, irq, tx_dma_req, rx_dma_req},
                  {5'd0, VEC[i][2:0]});
            @(negedge clk);
        end
        rd(1'b1, r); check("R2 ctrl readback", r, 8'h80);
        wr(1'b1, 8'h00);
        tx_fifo_full = 1'b1; rx_fifo_empty = 1'b1;

        // R4 clear rules
        wr(1'b0, 8'h00); rd(1'b0, r); check("R4 zero write", r, 8'h2D);
        wr(1'b0, 8'h12); rd(1'b0, r); check("R4 live bits", r, 8'h2D);
        wr(1'b0, 8'h04); rd(1'b0, r); check("R4 clear one", r, 8'h29);
        wr(1'b0, 8'h29); rd(1'b0, r); check("R4 clear rest", r, 8'h00);

        // R5 set beats clear
        xfer_done_evt = 1'b1; wr(1'b0, 8'h04); xfer_done_evt = 1'b0;
        rd(1'b0, r); check("R5 set wins", r, 8'h04);
        wr(1'b0, 8'h04);

        // R10 eoq with enable
        wr(1'b1, 8'h01); pulse(4'b0001); #1;
        check("R10 eoq irq", {7'd0, irq}, 8'h01);
        wr(1'b0, 8'h01); #1; check("R10 eoq cleared", {7'd0, irq}, 8'h00);

        // R9 acknowledge gap
        wr(1'b1, 8'hD2); tx_fifo_full = 1'b0; rx_fifo_empty = 1'b0; #1;
        check("R9 req before", {6'd0, tx_dma_req, rx_dma_req}, 8'h03);
        check("R8 routed no irq", {7'd0, irq}, 8'h00);
        tx_dma_ack = 1'b1; @(negedge clk); tx_dma_ack = 1'b0; #1;
        check("R9 tx gap", {6'd0, tx_dma_req, rx_dma_req}, 8'h01);
        @(negedge clk); #1;
        check("R9 tx resume", {6'd0, tx_dma_req, rx_dma_req}, 8'h03);
        rx_dma_ack = 1'b1; @(negedge clk); rx_dma_ack = 1'b0; #1;
        check("R9 rx gap", {6'd0, tx_dma_req, rx_dma_req}, 8'h02);
        @(negedge clk); #1;
        check("R9 rx resume", {6'd0, tx_dma_req, rx_dma_req}, 8'h03);

        finished = 1;
        summary();
    end
endmodule